// File: doc/BRIEF.md
# Fabric Interrupt Aggregation Controller

This block gathers a bank of 32 interrupt lines from the fabric into one wired interrupt for a parent controller. Each line owns one bit in a cause register that records activity and one bit in a mask register that gates that bit's effect on the output. A control register selects how activity is captured. The setting covers the whole instance: either every line is level-sensitive, or every line latches rising edges.

Software reaches the three registers over a small memory-mapped bus. The bus carries a byte address, a write strobe, write data and combinational read data. An interrupt service routine reads the cause register and filters it with the mask. It then acknowledges the bits it has handled by writing the cause register with zeros in those positions. The wired output stays high while at least one captured cause bit is unmasked.

Top module: `fabric_irq_aggregator`

## Requirements
- R1: After a synchronous active-low reset the mask register reads all ones, the cause register reads zero, the control register reads zero (level mode) and `irq_o` is low.
- R2: Registers sit at byte offsets 0x00 (cause), 0x10 (mask) and 0x28 (control). Reads of any other offset return zero and writes to them change nothing.
- R3: Mask bit n set to 1 blocks source n from `irq_o` and 0 lets it through. A mask write takes effect on the next clock and reads back exactly.
- R4: Control bit 3 selects capture for all sources, with 1 for rising edge and 0 for level. Control bit 5 is a plain stored bit with no effect. All other control bits read as zero.
- R5: In edge mode a cause bit sets when its input is high and was low in the previous cycle. It then stays set while the input stays high or falls, until software clears it.
- R6: In level mode a cause bit is set in every cycle its input is high. A clear written while the input is high leaves the bit set, and a clear written after the input has dropped removes it.
- R7: A cause write clears each bit where the write data holds 0 and leaves each bit where it holds 1. Writing all zeros clears every cause bit.
- R8: When a capture event and a clear of the same cause bit fall in the same cycle, the bit ends up set.
- R9: `irq_o` is high exactly when (cause AND NOT mask) is nonzero, one clock after the register update that produces that state.
- R10: Cause bits are captured while masked. Unmasking a bit that is already pending raises `irq_o` on the next clock without any new input activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 32 | Interrupt source lines, one per cause bit |
| reg_addr | input | 6 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe for the current address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Wired interrupt to the parent controller |

## Verification
A corrupted cause bit reaches the ports in the same cycle. It shows on a read of offset 0x00, and on `irq_o` as soon as that bit is unmasked, which can be a full service round later if the bit is masked. A stale edge reference shows only in edge mode. It appears as a missing or doubled capture on the first cycle after a line rises, so the bench reads the cause register on every cycle around such transitions. A mode bit that has flipped turns a held-high line into a bit that cannot be cleared, which the bench detects on the cycle after the clear.

// File: rtl/fic_pkg.sv
// Package: shared constants of the fabric interrupt aggregator.
// Assumes byte addressing with a 32-bit data path.
package fic_pkg;
    localparam int FIC_DATA_W      = 32;
    localparam int FIC_OFS_CAUSE   = 'h00;
    localparam int FIC_OFS_MASK    = 'h10;
    localparam int FIC_OFS_CTRL    = 'h28;
    localparam int FIC_CTRL_EDGE   = 3;
    localparam int FIC_CTRL_MSGMSK = 5;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CAUSE = 2'd1,
        SEL_MASK  = 2'd2,
        SEL_CTRL  = 2'd3
    } fic_sel_e;
endpackage

// File: rtl/fic_addr_decode.sv
// Module: fic_addr_decode
// Decodes the byte offset into a register select and per-register write
// strobes. It assumes one access per cycle and treats any unmapped offset
// as a no-op.
module fic_addr_decode
    import fic_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output fic_sel_e          sel,
    output logic              wr_cause,
    output logic              wr_mask,
    output logic              wr_ctrl
);
    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(FIC_OFS_CAUSE);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(FIC_OFS_MASK);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(FIC_OFS_CTRL);

    // Map the offset onto one register select.
    always_comb begin
        if (addr == A_CAUSE)      sel = SEL_CAUSE;
        else if (addr == A_MASK)  sel = SEL_MASK;
        else if (addr == A_CTRL)  sel = SEL_CTRL;
        else                      sel = SEL_NONE;
    end

    // Qualify the select with the write strobe.
    always_comb begin
        wr_cause = we && (sel == SEL_CAUSE);
        wr_mask  = we && (sel == SEL_MASK);
        wr_ctrl  = we && (sel == SEL_CTRL);
    end
endmodule

// File: rtl/fic_cfg_regs.sv
// Module: fic_cfg_regs
// Holds the mask register and the two defined control bits. Reset leaves
// every source masked and the instance in level mode. Undefined control
// bits are not stored.
module fic_cfg_regs
    import fic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_mask,
    input  logic               wr_ctrl,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] mask_q,
    output logic               edge_mode,
    output logic               msg_mask,
    output logic [NUM_SRC-1:0] ctrl_view
);
    // Mask register: all ones out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (wr_mask) mask_q <= wdata;
    end

    // Control storage: trigger mode and message-interrupt mask bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_mode <= 1'b0;
            msg_mask  <= 1'b0;
        end else if (wr_ctrl) begin
            edge_mode <= wdata[FIC_CTRL_EDGE];
            msg_mask  <= wdata[FIC_CTRL_MSGMSK];
        end
    end

    // Place the stored control bits at their register positions.
    always_comb begin
        ctrl_view                  = '0;
        ctrl_view[FIC_CTRL_EDGE]   = edge_mode;
        ctrl_view[FIC_CTRL_MSGMSK] = msg_mask;
    end
endmodule

// File: rtl/fic_cause_capture.sv
// Module: fic_cause_capture
// Per-source capture into the cause register. In edge mode a bit sets on a
// low-to-high step against a registered copy of the input; in level mode it
// sets whenever the input is high. A software write clears the bits written
// as 0, and a capture in the same cycle takes precedence over the clear.
module fic_cause_capture #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic               edge_mode,
    input  logic               wr_cause,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] cause_q,
    output logic [NUM_SRC-1:0] prev_q
);
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] keep_vec;

    // Per-source capture event selected by the instance-wide mode.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign set_vec[i] = edge_mode ? (src[i] & ~prev_q[i]) : src[i];
    end

    // Bits that survive this cycle's acknowledge write.
    always_comb begin
        keep_vec = wr_cause ? (cause_q & wdata) : cause_q;
    end

    // Edge reference: previous-cycle sample of every source.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src;
    end

    // Cause register update: capture wins over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= keep_vec | set_vec;
    end
endmodule

// File: rtl/fabric_irq_aggregator.sv
// Module: fabric_irq_aggregator
// Top level: folds NUM_SRC interrupt lines into one wired interrupt. It
// assumes src_i is synchronous to clk and that NUM_SRC equals the 32-bit
// register width. Read data is combinational from reg_addr.
module fabric_irq_aggregator
    import fic_pkg::*;
#(
    parameter int NUM_SRC = FIC_DATA_W,
    parameter int ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_we,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               irq_o
);
    fic_sel_e           sel;
    logic               wr_cause;
    logic               wr_mask;
    logic               wr_ctrl;
    logic [NUM_SRC-1:0] mask_vec;
    logic [NUM_SRC-1:0] cause_vec;
    logic [NUM_SRC-1:0] prev_vec;
    logic [NUM_SRC-1:0] ctrl_vec;
    logic               edge_mode;
    logic               msg_mask;

    fic_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr     (reg_addr),
        .we       (reg_we),
        .sel      (sel),
        .wr_cause (wr_cause),
        .wr_mask  (wr_mask),
        .wr_ctrl  (wr_ctrl)
    );

    fic_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask   (wr_mask),
        .wr_ctrl   (wr_ctrl),
        .wdata     (reg_wdata),
        .mask_q    (mask_vec),
        .edge_mode (edge_mode),
        .msg_mask  (msg_mask),
        .ctrl_view (ctrl_vec)
    );

    fic_cause_capture #(.NUM_SRC(NUM_SRC)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (src_i),
        .edge_mode (edge_mode),
        .wr_cause  (wr_cause),
        .wdata     (reg_wdata),
        .cause_q   (cause_vec),
        .prev_q    (prev_vec)
    );

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        unique case (sel)
            SEL_CAUSE: reg_rdata = cause_vec;
            SEL_MASK:  reg_rdata = mask_vec;
            SEL_CTRL:  reg_rdata = ctrl_vec;
            default:   reg_rdata = '0;
        endcase
    end

    // Wired output: any pending, unmasked cause.
    always_comb begin
        irq_o = |(cause_vec & ~mask_vec);
    end
endmodule

// File: rtl/fic_checker.sv
// Module: fic_checker
// Temporal checks on the aggregator, attached by bind below. It relates
// register state across cycles to the bus and source inputs.
module fic_checker
    import fic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_we,
    input logic [NUM_SRC-1:0] reg_wdata,
    input logic [NUM_SRC-1:0] cause_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] prev_q,
    input logic               edge_mode
);
    logic cause_wr;
    logic mask_wr;
    assign cause_wr = reg_we && (reg_addr == ADDR_W'(FIC_OFS_CAUSE));
    assign mask_wr  = reg_we && (reg_addr == ADDR_W'(FIC_OFS_MASK));

    // R3: a mask write lands exactly on the next clock.
    a_r3_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_q == $past(reg_wdata)));

    // R5: every rising edge seen in edge mode is captured.
    a_r5_edge_capture: assert property (@(posedge clk) disable iff (!rst_n)
        edge_mode |=> ((cause_q & ($past(src_i) & ~$past(prev_q)))
                       == ($past(src_i) & ~$past(prev_q))));

    // R6: in level mode every high input is captured.
    a_r6_level_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode |=> ((cause_q & $past(src_i)) == $past(src_i)));

    // R7: without an acknowledge write no cause bit drops.
    a_r7_sticky_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_wr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

    // R8: after an acknowledge, only kept or newly captured bits remain.
    a_r8_clear_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_wr && !edge_mode) |=>
            ((cause_q & ~$past(reg_wdata) & ~$past(src_i)) == '0));
endmodule

bind fabric_irq_aggregator fic_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .cause_q   (cause_vec),
    .mask_q    (mask_vec),
    .prev_q    (prev_vec),
    .edge_mode (edge_mode)
);

// File: tb/fabric_irq_aggregator_tb.sv
`timescale 1ns/1ps
module fabric_irq_aggregator_tb;
    localparam int NS = 32;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_i = '0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_we = 1'b0;
    logic [NS-1:0] reg_wdata = '0;
    logic [NS-1:0] reg_rdata;
    logic          irq_o;

    int n_chk = 0;
    int n_bad = 0;

    // Reference state built from the requirements.
    logic [31:0] m_cause, m_mask, m_ctrl, m_prev;

    always #2.5 clk = ~clk;

    fabric_irq_aggregator u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [5:0] a);
        case (a)
            6'h00:   return m_cause;   // R2
            6'h10:   return m_mask;
            6'h28:   return m_ctrl;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic m_irq();
        return |(m_cause & ~m_mask);   // R9
    endfunction

    task automatic m_reset();
        m_cause = '0; m_mask = '1; m_ctrl = '0; m_prev = '0;
    endtask

    // Advance the reference by one clock with the given inputs.
    task automatic m_step(input logic [31:0] s, input logic we, input logic [5:0] a,
                          input logic [31:0] d);
        logic [31:0] setv;
        setv = m_ctrl[3] ? (s & ~m_prev) : s;              // R4 R5 R6
        m_cause = ((we && a == 6'h00) ? (m_cause & d) : m_cause) | setv; // R7 R8
        if (we && a == 6'h10) m_mask = d;
        if (we && a == 6'h28) m_ctrl = d & 32'h28;
        m_prev = s;
    endtask

    // One cycle: drive, check state left by the previous edge, advance model.
    task automatic cyc(input logic [31:0] s, input logic we, input logic [5:0] a,
                       input logic [31:0] d, input string req);
        @(negedge clk);
        src_i = s; reg_we = we; reg_addr = a; reg_wdata = d;
        #1;
        check(req, reg_rdata, m_read(a));
        check({req, " irq"}, {31'd0, irq_o}, {31'd0, m_irq()});
        m_step(s, we, a, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_we = 1'b0; src_i = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_reset();
    endtask

    task automatic random_phase(input int n);
        logic [31:0] s = '0;
        for (int i = 0; i < n; i++) begin
            logic [5:0]  a;
            logic [31:0] d;
            logic        we;
            int          r;
            if (($urandom % 4) != 0) s = $urandom & $urandom & $urandom;
            r = $urandom % 8;
            we = (r < 2);
            case ($urandom % 5)
                0, 1:    a = 6'h00;
                2:       a = 6'h10;
                3:       a = 6'h28;
                default: a = 6'($urandom);
            endcase
            if (we && a == 6'h28) a = 6'h00;   // keep mode fixed in a phase
            d = (a == 6'h00) ? ~($urandom & $urandom) : $urandom;
            cyc(s, we, a, d, "R9 random");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1: reset values
        cyc('0, 0, 6'h00, 0, "R1 cause");
        cyc('0, 0, 6'h10, 0, "R1 mask");
        cyc('0, 0, 6'h28, 0, "R1 ctrl");
        // R2: unmapped offsets read zero and ignore writes
        cyc('0, 1, 6'h04, '1, "R2 write hole");
        cyc('0, 0, 6'h04, 0, "R2 hole");
        cyc('0, 0, 6'h2C, 0, "R2 hole");
        cyc('0, 0, 6'h10, 0, "R2 mask intact");
        // R4: control bits, others read zero
        cyc('0, 1, 6'h28, 32'hFFFF_FFF7, "R4 write");
        cyc('0, 0, 6'h28, 0, "R4 readback");
        cyc('0, 1, 6'h28, 32'h0, "R4 level");
        // R10: capture while masked, then unmask
        cyc(32'h0000_0100, 0, 6'h00, 0, "R10 masked src");
        cyc('0, 0, 6'h00, 0, "R10 captured");
        cyc('0, 1, 6'h10, 32'hFFFF_FEFF, "R10 unmask");
        cyc('0, 0, 6'h10, 0, "R10 irq");
        // R7: writing ones keeps, zeros clear
        cyc('0, 1, 6'h00, '1, "R7 keep");
        cyc('0, 0, 6'h00, 0, "R7 kept");
        cyc('0, 1, 6'h00, 0, "R7 clear all");
        cyc('0, 0, 6'h00, 0, "R7 cleared");
        // R6: level clear while high has no effect, after drop it works
        cyc(32'h1, 1, 6'h10, 32'h0, "R6 unmask");
        cyc(32'h1, 1, 6'h00, 0, "R6 clear high");
        cyc('0, 0, 6'h00, 0, "R6 still set");
        cyc('0, 1, 6'h00, 0, "R6 clear low");
        cyc('0, 0, 6'h00, 0, "R6 gone");
        // R5: edge mode capture and hold
        cyc('0, 1, 6'h28, 32'h08, "R5 edge on");
        cyc(32'h3, 0, 6'h00, 0, "R5 rise");
        cyc(32'h3, 0, 6'h00, 0, "R5 captured");
        cyc(32'h3, 1, 6'h00, 0, "R5 clear while high");
        cyc(32'h2, 0, 6'h00, 0, "R5 no recapture");
        cyc(32'h0, 0, 6'h00, 0, "R5 fall");
        // R8: rising edge in the clearing cycle wins
        cyc(32'h4, 1, 6'h00, 0, "R8 edge and clear");
        cyc('0, 0, 6'h00, 0, "R8 set wins");
        cyc('0, 1, 6'h00, 0, "R8 tidy");
        // R3: mask readback and gating
        cyc('0, 1, 6'h10, 32'hA5A5_5A5A, "R3 write");
        cyc('0, 0, 6'h10, 0, "R3 readback");
        cyc(32'h0000_0002, 0, 6'h00, 0, "R3 masked edge");
        cyc('0, 0, 6'h00, 0, "R3 irq low");
        // Random phases in both modes
        random_phase(3000);
        cyc('0, 1, 6'h28, 32'h20, "R4 level msg");
        cyc('0, 0, 6'h28, 0, "R4 msg bit");
        random_phase(3000);
        do_reset();
        cyc('0, 0, 6'h10, 0, "R1 mask again");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule